// File: doc/BRIEF.md
# Fault-Class Majority Voter

This block smooths the decisions of a six-way fault classifier by voting over time. Each time the classifier finishes a pattern it raises a one-cycle done strobe together with a class index. The voter keeps one counter per class and one counter for the number of votes in the current batch. When the batch reaches its length, a chain of comparators finds the class with the most votes. The winning class and its vote count are held on the outputs, and a one-cycle valid pulse announces them.

Class index 0 means a healthy winding, and class k (1 to 5) means k shorted turns. The batch length comes from a port, so a longer batch can be chosen for a steadier verdict at the cost of a longer wait. The value 0 on that port selects a built-in default of ten patterns. A display or status register downstream captures the verdict on the valid pulse.

Top module: `fault_vote_top`

## Requirements
- R1: While reset is asserted and after its release, verdict_valid_o, verdict_class_o and verdict_votes_o are 0 until the first verdict.
- R2: A clock edge with done_i high and class_i in 0..5 counts one vote: the count of that class and the batch count each rise by exactly one, and no other class count changes.
- R3: A done_i strobe with class_i equal to 6 or 7 is ignored. It changes no count and does not advance the batch.
- R4: A nonzero batch_len_i sets the number of votes per batch. batch_len_i = 0 selects the default length DEF_BATCH, which is 10.
- R5: The verdict class is the class with the most votes in the batch, and verdict_votes_o is that number of votes. Class 0 = no fault, class k = k shorted turns.
- R6: When two or more classes share the highest count, the lowest class index is reported.
- R7: If the vote that completes a batch is taken at edge N, then verdict_class_o and verdict_votes_o change at edge N+1 and verdict_valid_o is high for the single cycle that follows. The verdict holds until the next verdict.
- R8: At edge N+1 every count is cleared. A vote taken at that same edge counts as the first vote of the new batch.
- R9: The batch-complete test is made at each counted vote against the batch_len_i present at that moment. If the length is lowered below the votes already counted, the batch completes at the next counted vote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| done_i | input | 1 | Classifier finished one pattern |
| class_i | input | 3 | Class index of that pattern |
| batch_len_i | input | 8 | Votes per batch; 0 selects the default |
| verdict_valid_o | output | 1 | One-cycle pulse: a new verdict is on the outputs |
| verdict_class_o | output | 3 | Majority class of the last batch |
| verdict_votes_o | output | 8 | Votes the winning class received |

## Verification
A stuck or mis-steered class counter shows up at the ports at the end of the batch it corrupts. The verdict then names the wrong class or reports the wrong vote count, so the error is visible at most one batch length plus two cycles after the fault. A batch counter that drifts, or that advances on the rejected indices 6 and 7, moves the valid pulse off the cycle the reference model predicts. A missed clear carries votes into the next batch and raises its vote count. Ties, the minimum length of one, back-to-back batches and a shortened length are all driven, so each of these internal errors is seen within a few cycles of the batch it touches.

// File: rtl/fvote_pkg.sv
package fvote_pkg;

  // a vote is counted only when its class index names a real class
  function automatic logic class_ok(input int unsigned idx, input int unsigned n_cls);
    return idx < n_cls;
  endfunction

  // a later class replaces the leader only on a strictly higher count,
  // so the lower index keeps ties
  function automatic logic takes_lead(input int unsigned cand, input int unsigned lead);
    return cand > lead;
  endfunction

  // a requested length of zero selects the default batch
  function automatic int unsigned eff_len(input int unsigned req, input int unsigned dflt);
    return (req == 0) ? dflt : req;
  endfunction

endpackage

// File: rtl/fvote_batch_ctrl.sv
module fvote_batch_ctrl
  import fvote_pkg::*;
#(
  parameter int unsigned NUM_CLASS = 6,
  parameter int unsigned CLASS_W   = 3,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned DEF_BATCH = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic [CLASS_W-1:0] class_i,
  input  logic [CNT_W-1:0]   batch_len_i,
  input  logic [CNT_W-1:0]   batch_cnt_i,
  output logic               accept_o,
  output logic               eval_o
);

  logic        full_q;
  int unsigned base_cnt;
  int unsigned target;

  assign accept_o = done_i && class_ok(32'(class_i), NUM_CLASS);
  assign eval_o   = full_q;

  // in the evaluation cycle the counters restart, so a vote there is the first
  assign base_cnt = eval_o ? 32'd0 : 32'(batch_cnt_i);
  assign target   = eff_len(32'(batch_len_i), DEF_BATCH);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
    end else begin
      full_q <= accept_o && ((base_cnt + 32'd1) >= target);
    end
  end

endmodule

// File: rtl/fvote_bucket_bank.sv
module fvote_bucket_bank #(
  parameter int unsigned NUM_CLASS = 6,
  parameter int unsigned CLASS_W   = 3,
  parameter int unsigned CNT_W     = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            accept_i,
  input  logic [CLASS_W-1:0]              class_i,
  input  logic                            clear_i,
  output logic [NUM_CLASS-1:0][CNT_W-1:0] bucket_o,
  output logic [CNT_W-1:0]                batch_o,
  output logic [NUM_CLASS-1:0]            inc_o
);

  logic [CNT_W-1:0] batch_q;

  for (genvar g = 0; g < NUM_CLASS; g++) begin : bucket
    logic [CNT_W-1:0] cnt_q;

    assign inc_o[g] = accept_i && (class_i == CLASS_W'(g));

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (clear_i) begin
        cnt_q <= inc_o[g] ? CNT_W'(1) : '0;
      end else if (inc_o[g]) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end

    assign bucket_o[g] = cnt_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      batch_q <= '0;
    end else if (clear_i) begin
      batch_q <= accept_i ? CNT_W'(1) : '0;
    end else if (accept_i) begin
      batch_q <= batch_q + CNT_W'(1);
    end
  end

  assign batch_o = batch_q;

endmodule

// File: rtl/fvote_argmax_chain.sv
module fvote_argmax_chain
  import fvote_pkg::*;
#(
  parameter int unsigned NUM_CLASS = 6,
  parameter int unsigned CLASS_W   = 3,
  parameter int unsigned CNT_W     = 8
) (
  input  logic [NUM_CLASS-1:0][CNT_W-1:0] bucket_i,
  output logic [CLASS_W-1:0]              win_idx_o,
  output logic [CNT_W-1:0]                win_cnt_o
);

  for (genvar g = 0; g < NUM_CLASS; g++) begin : stage
    logic [CLASS_W-1:0] idx;
    logic [CNT_W-1:0]   cnt;

    if (g == 0) begin : seed
      assign idx = '0;
      assign cnt = bucket_i[0];
    end else begin : cmp
      always_comb begin
        if (takes_lead(32'(bucket_i[g]), 32'(stage[g-1].cnt))) begin
          idx = CLASS_W'(g);
          cnt = bucket_i[g];
        end else begin
          idx = stage[g-1].idx;
          cnt = stage[g-1].cnt;
        end
      end
    end
  end

  assign win_idx_o = stage[NUM_CLASS-1].idx;
  assign win_cnt_o = stage[NUM_CLASS-1].cnt;

endmodule

// File: rtl/fvote_verdict_reg.sv
module fvote_verdict_reg #(
  parameter int unsigned CLASS_W = 3,
  parameter int unsigned CNT_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [CLASS_W-1:0] idx_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic               valid_o,
  output logic [CLASS_W-1:0] idx_o,
  output logic [CNT_W-1:0]   cnt_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
      cnt_o   <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        idx_o <= idx_i;
        cnt_o <= cnt_i;
      end
    end
  end

endmodule

// File: rtl/fault_vote_top.sv
module fault_vote_top #(
  parameter int unsigned NUM_CLASS = 6,
  parameter int unsigned MAX_BATCH = 255,
  parameter int unsigned DEF_BATCH = 10,
  localparam int unsigned CLASS_W  = $clog2(NUM_CLASS + 1),
  localparam int unsigned CNT_W    = $clog2(MAX_BATCH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic [CLASS_W-1:0] class_i,
  input  logic [CNT_W-1:0]   batch_len_i,
  output logic               verdict_valid_o,
  output logic [CLASS_W-1:0] verdict_class_o,
  output logic [CNT_W-1:0]   verdict_votes_o
);

  // named internal events, also observed by the checker
  logic                            accept_w;
  logic                            eval_w;
  logic [CNT_W-1:0]                batch_cnt_w;
  logic [NUM_CLASS-1:0]            bucket_inc_w;
  logic [NUM_CLASS-1:0][CNT_W-1:0] bucket_w;
  logic [CLASS_W-1:0]              win_idx_w;
  logic [CNT_W-1:0]                win_cnt_w;

  fvote_batch_ctrl #(
    .NUM_CLASS (NUM_CLASS),
    .CLASS_W   (CLASS_W),
    .CNT_W     (CNT_W),
    .DEF_BATCH (DEF_BATCH)
  ) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done_i),
    .class_i     (class_i),
    .batch_len_i (batch_len_i),
    .batch_cnt_i (batch_cnt_w),
    .accept_o    (accept_w),
    .eval_o      (eval_w)
  );

  fvote_bucket_bank #(
    .NUM_CLASS (NUM_CLASS),
    .CLASS_W   (CLASS_W),
    .CNT_W     (CNT_W)
  ) bank_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept_w),
    .class_i  (class_i),
    .clear_i  (eval_w),
    .bucket_o (bucket_w),
    .batch_o  (batch_cnt_w),
    .inc_o    (bucket_inc_w)
  );

  fvote_argmax_chain #(
    .NUM_CLASS (NUM_CLASS),
    .CLASS_W   (CLASS_W),
    .CNT_W     (CNT_W)
  ) chain_i (
    .bucket_i  (bucket_w),
    .win_idx_o (win_idx_w),
    .win_cnt_o (win_cnt_w)
  );

  fvote_verdict_reg #(
    .CLASS_W (CLASS_W),
    .CNT_W   (CNT_W)
  ) verdict_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (eval_w),
    .idx_i   (win_idx_w),
    .cnt_i   (win_cnt_w),
    .valid_o (verdict_valid_o),
    .idx_o   (verdict_class_o),
    .cnt_o   (verdict_votes_o)
  );

endmodule

// File: rtl/fault_vote_chk.sv
module fault_vote_chk #(
  parameter int unsigned NUM_CLASS = 6,
  parameter int unsigned CLASS_W   = 3,
  parameter int unsigned CNT_W     = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 done_i,
  input logic [CLASS_W-1:0]   class_i,
  input logic                 accept_w,
  input logic                 eval_w,
  input logic [CNT_W-1:0]     batch_cnt_w,
  input logic [NUM_CLASS-1:0] bucket_inc_w,
  input logic                 verdict_valid_o,
  input logic [CNT_W-1:0]     verdict_votes_o
);

  // R2
  batch_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_w && !eval_w) |=> (batch_cnt_w == CNT_W'($past(batch_cnt_w) + CNT_W'(1))));

  // R2
  single_bucket_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bucket_inc_w));

  // R3
  reject_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && (32'(class_i) >= NUM_CLASS) && !eval_w) |=> $stable(batch_cnt_w));

  // R8
  clear_after_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |-> (batch_cnt_w == ($past(accept_w) ? CNT_W'(1) : CNT_W'(0))));

  // R5
  winner_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |-> (verdict_votes_o != '0));

  // R7
  verdict_after_batch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |-> ($past(batch_cnt_w) != '0));

endmodule

bind fault_vote_top fault_vote_chk #(
  .NUM_CLASS (NUM_CLASS),
  .CLASS_W   (CLASS_W),
  .CNT_W     (CNT_W)
) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .done_i          (done_i),
  .class_i         (class_i),
  .accept_w        (accept_w),
  .eval_w          (eval_w),
  .batch_cnt_w     (batch_cnt_w),
  .bucket_inc_w    (bucket_inc_w),
  .verdict_valid_o (verdict_valid_o),
  .verdict_votes_o (verdict_votes_o)
);

// File: tb/fault_vote_top_tb_top.sv
`timescale 1ns/1ps
module fault_vote_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       done = 1'b0;
  logic [2:0] cls = 3'd0;
  logic [7:0] len = 8'd0;
  logic       v_valid;
  logic [2:0] v_class;
  logic [7:0] v_votes;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;
  string cur_req = "R1";

  // reference model state
  int cnt[6];
  int batch = 0;
  bit pend = 0;
  bit exp_valid = 0;
  int exp_cls = 0;
  int exp_votes = 0;

  always #10 clk = ~clk;

  fault_vote_top dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .done_i          (done),
    .class_i         (cls),
    .batch_len_i     (len),
    .verdict_valid_o (v_valid),
    .verdict_class_o (v_class),
    .verdict_votes_o (v_votes)
  );

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // behavioural model: tallies in an array, verdict chosen by a scan
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (cnt[i]) cnt[i] = 0;
      batch = 0; pend = 0; exp_valid = 0; exp_cls = 0; exp_votes = 0;
    end else begin
      exp_valid = 0;
      if (pend) begin
        int best;
        best = 0;
        for (int c = 1; c < 6; c++) if (cnt[c] > cnt[best]) best = c;
        exp_cls = best; exp_votes = cnt[best]; exp_valid = 1;
        foreach (cnt[i]) cnt[i] = 0;
        batch = 0;
      end
      pend = 0;
      if (done && int'(cls) < 6) begin
        int lim;
        cnt[int'(cls)]++;
        batch++;
        lim = (len == 0) ? 10 : int'(len);
        if (batch >= lim) pend = 1;
      end
    end
    #5;
    if (!finished) begin
      check("valid", int'(v_valid), int'(exp_valid));
      check("class", int'(v_class), exp_cls);
      check("votes", int'(v_votes), exp_votes);
    end
  end

  task automatic step(input bit d, input int c);
    @(negedge clk);
    done = d;
    cls = 3'(c);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, i % 8);
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check("reset valid", int'(v_valid), 0);
    check("reset class", int'(v_class), 0);
    rst_n = 1'b1;
    idle(3);
    check("post-reset votes", int'(v_votes), 0);

    // default length of ten, majority class 3 (R4, R2, R5)
    cur_req = "R4";
    len = 8'd0;
    begin
      int seq[10] = '{3, 1, 3, 0, 3, 5, 3, 2, 1, 3};
      foreach (seq[i]) begin step(1, seq[i]); step(0, 0); end
    end
    idle(3);
    check("R4 default verdict class", int'(v_class), 3);
    check("R2 votes for class 3", int'(v_votes), 5);

    // explicit length seven, five shorted turns most frequent (R5, R7)
    cur_req = "R5";
    len = 8'd7;
    begin
      int seq[7] = '{5, 0, 5, 4, 5, 0, 5};
      foreach (seq[i]) step(1, seq[i]);
    end
    cur_req = "R7";
    idle(4);
    check("R5 verdict class", int'(v_class), 5);

    // tie between classes 2 and 4: lower index wins (R6)
    cur_req = "R6";
    len = 8'd4;
    step(1, 4); step(1, 2); step(1, 4); step(1, 2);
    idle(3);
    check("R6 tie winner", int'(v_class), 2);
    check("R6 tie votes", int'(v_votes), 2);

    // invalid indices interleaved, must not advance the batch (R3)
    cur_req = "R3";
    len = 8'd3;
    step(1, 1); step(1, 6); step(1, 7); step(1, 1); step(1, 7); step(0, 0); step(1, 0);
    idle(3);
    check("R3 verdict ignores 6/7", int'(v_class), 1);
    check("R3 votes", int'(v_votes), 2);

    // length one, votes every cycle: each evaluation cycle vote starts a new batch (R8)
    cur_req = "R8";
    len = 8'd1;
    step(1, 1); step(1, 2); step(1, 3); step(1, 4);
    idle(3);
    check("R8 last single-vote verdict", int'(v_class), 4);

    // back-to-back batches of two with a vote in the evaluation cycle (R8)
    len = 8'd2;
    step(1, 0); step(1, 5); step(1, 5); step(1, 5);
    idle(4);

    // shortening the length mid-batch (R9)
    cur_req = "R9";
    len = 8'd20;
    step(1, 2); step(1, 2); step(1, 0); step(1, 2); step(1, 1);
    idle(2);
    check("R9 no verdict yet", int'(v_valid), 0);
    len = 8'd3;
    idle(2);
    step(1, 0);
    idle(3);
    check("R9 shortened verdict", int'(v_class), 2);
    check("R9 shortened votes", int'(v_votes), 3);

    // the held verdict does not move while idle (R7)
    cur_req = "R7";
    idle(10);
    check("R7 held class", int'(v_class), 2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule